// File: doc/BRIEF.md
# Audio Frame Sequencer with Interrupt

This block produces the timing strobes for the slow-rate units of a retro sound generator: a quarter-frame pulse for the envelope and linear-counter units, and a half-frame pulse for the length and sweep units. It also raises a frame interrupt at the end of each frame. It is clocked by the CPU clock. An internal parity bit lets the sequence counter advance only on every second CPU cycle, so one sequencer tick takes two CPU cycles.

Software reaches the block through a single-cycle access strobe. Each access targets either the mode register or the status register. A mode write selects the 4-step or the 5-step sequence and the interrupt inhibit. It also restarts the sequence counter from zero, and it leaves the parity phase untouched. A status read acknowledges the frame interrupt. A status write and a mode read have no effect on the block. The control pins are plain strobes, so there is no stream interface and no back-pressure.

Timing is given in CPU clock edges. Edge 0 is the edge that samples the mode write. An output that is "visible at N" is high in the cycle that follows edge N.

Top module: `frame_sequencer`

## Requirements
- R1: The parity bit is 0 out of reset and toggles on every clock edge. The sequence counter advances only on an edge where the parity bit is 1 before that edge, so there is one tick every two CPU cycles.
- R2: After a mode write taken on an edge where the parity bit is 0, the first quarter-frame pulse is visible at edge 7457.
- R3: In 4-step mode (with the same phase as in R2), half-frame pulses are visible at edges 14913 and 29829. That is 14916 cycles apart, and the sequence then repeats every 29830 cycles.
- R4: In 4-step mode with the interrupt not inhibited, the frame interrupt goes high at edge 29829. It stays high until it is cleared, so it is pending at edge 29832.
- R5: A status read (acc_valid=1, acc_write=0, acc_sel_mode=0) clears the frame interrupt on the next edge. The clear takes priority over a set on the same edge.
- R6: A status write (acc_valid=1, acc_write=1, acc_sel_mode=0) leaves a pending frame interrupt high.
- R7: Bit 1 of the mode write data is the interrupt inhibit. A mode write with this bit set clears a pending interrupt on that edge. While the bit is set, no new interrupt is raised.
- R8: Bit 0 of the mode write data selects 5-step mode. In 5-step mode, half-frame pulses are visible at edges 14913 and 37281, the frame lasts 37282 cycles, and the frame interrupt is never raised.
- R9: A mode write restarts the sequence counter from zero and keeps the parity phase. If the write is taken on an edge where the parity bit is 1, the first quarter-frame pulse is visible at edge 7458. No pulse is visible in the cycle right after a mode write.
- R10: Each pulse lasts one cycle. Every half-frame pulse coincides with a quarter-frame pulse.
- R11: Out of reset, all outputs are low and the mode is 4-step with the interrupt enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Single-cycle register access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_sel_mode | input | 1 | 1 = mode register, 0 = status register |
| acc_data | input | 2 | Mode write data: bit 0 selects 5-step mode, bit 1 sets the interrupt inhibit |
| qtr_pulse | output | 1 | Quarter-frame clock pulse |
| half_pulse | output | 1 | Half-frame clock pulse |
| frame_irq | output | 1 | Frame interrupt, level |

## Verification
The assertions assume that at most one access happens per cycle and that each access lasts exactly one cycle. The port encoding enforces the first assumption: a mode write and a status read can never occur on the same edge. The bench drives every access for a single cycle between negative edges and returns to idle afterwards. It also chooses the parity phase of each mode write by waiting on its own model of the parity bit, so that both phases of R9 are exercised.

// File: rtl/fs_pkg.sv
package fs_pkg;
  localparam int unsigned MODE_BIT_FIVE = 0;
  localparam int unsigned MODE_BIT_INH  = 1;
  localparam int unsigned MODE_W        = 2;

  typedef struct packed {
    logic irq_inhibit;
    logic five_step;
  } fs_mode_t;

  function automatic fs_mode_t decode_mode(input logic [MODE_W-1:0] d);
    fs_mode_t m;
    m.five_step   = d[MODE_BIT_FIVE];
    m.irq_inhibit = d[MODE_BIT_INH];
    return m;
  endfunction
endpackage

// File: rtl/fs_parity.sv
module fs_parity (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  logic par_q;

  always_ff @(posedge clk) begin
    if (!rst_n) par_q <= 1'b0;
    else        par_q <= ~par_q;
  end

  assign tick_o = par_q;
endmodule

// File: rtl/fs_step_counter.sv
module fs_step_counter #(
  parameter int unsigned CNT_W  = 15,
  parameter int unsigned END4   = 14915,
  parameter int unsigned END5   = 18641
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             advance,
  input  logic             five_step,
  output logic [CNT_W-1:0] count_next
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] end_sel;
  logic             at_end;

  assign count_next = cnt_q + CNT_W'(1);
  assign end_sel    = five_step ? CNT_W'(END5) : CNT_W'(END4);
  assign at_end     = (count_next == end_sel);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (advance) cnt_q <= at_end ? '0 : count_next;
  end
endmodule

// File: rtl/fs_step_decode.sv
module fs_step_decode #(
  parameter int unsigned CNT_W = 15,
  parameter int unsigned Q1    = 3729,
  parameter int unsigned H1    = 7457,
  parameter int unsigned Q3    = 11186,
  parameter int unsigned END4  = 14915,
  parameter int unsigned END5  = 18641
) (
  input  logic [CNT_W-1:0] count_next,
  input  logic             five_step,
  output logic             qtr,
  output logic             half,
  output logic             irq_point
);
  localparam int unsigned NPTS = 3;
  localparam int unsigned PTS [NPTS] = '{Q1, H1, Q3};
  localparam int unsigned HALF_IDX = 1;

  logic [NPTS-1:0] mid_hit;
  logic            end_hit;

  for (genvar i = 0; i < NPTS; i++) begin : g_mid
    assign mid_hit[i] = (count_next == CNT_W'(PTS[i]));
  end

  assign end_hit   = five_step ? (count_next == CNT_W'(END5))
                               : (count_next == CNT_W'(END4));
  assign qtr       = (|mid_hit) | end_hit;
  assign half      = mid_hit[HALF_IDX] | end_hit;
  assign irq_point = !five_step && (count_next == CNT_W'(END4));
endmodule

// File: rtl/fs_irq_flag.sv
module fs_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_o
);
  logic irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     irq_q <= 1'b0;
    else if (clr_i) irq_q <= 1'b0;
    else if (set_i) irq_q <= 1'b1;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/frame_sequencer.sv
module frame_sequencer #(
  parameter int unsigned Q1   = 3729,
  parameter int unsigned H1   = 7457,
  parameter int unsigned Q3   = 11186,
  parameter int unsigned END4 = 14915,
  parameter int unsigned END5 = 18641
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_valid,
  input  logic       acc_write,
  input  logic       acc_sel_mode,
  input  logic [1:0] acc_data,
  output logic       qtr_pulse,
  output logic       half_pulse,
  output logic       frame_irq
);
  import fs_pkg::*;

  localparam int unsigned CNT_W = $clog2(END5 + 1);

  logic             tick;
  logic             mode_wr;
  logic             stat_rd;
  logic             step_ev;
  fs_mode_t         mode_q;
  fs_mode_t         mode_new;
  logic [CNT_W-1:0] count_next;
  logic             dec_qtr, dec_half, dec_irq;
  logic             qtr_q, half_q;

  assign mode_wr  = acc_valid & acc_write & acc_sel_mode;
  assign stat_rd  = acc_valid & ~acc_write & ~acc_sel_mode;
  assign mode_new = decode_mode(acc_data);

  always_ff @(posedge clk) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_wr) mode_q <= mode_new;
  end

  fs_parity u_par (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick)
  );

  fs_step_counter #(.CNT_W(CNT_W), .END4(END4), .END5(END5)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (mode_wr),
    .advance    (tick),
    .five_step  (mode_q.five_step),
    .count_next (count_next)
  );

  fs_step_decode #(.CNT_W(CNT_W), .Q1(Q1), .H1(H1), .Q3(Q3),
                   .END4(END4), .END5(END5)) u_dec (
    .count_next (count_next),
    .five_step  (mode_q.five_step),
    .qtr        (dec_qtr),
    .half       (dec_half),
    .irq_point  (dec_irq)
  );

  assign step_ev = tick & ~mode_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      qtr_q  <= 1'b0;
      half_q <= 1'b0;
    end else begin
      qtr_q  <= step_ev & dec_qtr;
      half_q <= step_ev & dec_half;
    end
  end

  fs_irq_flag u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (step_ev & dec_irq & ~mode_q.irq_inhibit),
    .clr_i (stat_rd | (mode_wr & mode_new.irq_inhibit)),
    .irq_o (frame_irq)
  );

  assign qtr_pulse  = qtr_q;
  assign half_pulse = half_q;
endmodule

// File: rtl/fs_checks.sv
module fs_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       acc_valid,
  input logic       acc_write,
  input logic       acc_sel_mode,
  input logic [1:0] acc_data,
  input logic       qtr_pulse,
  input logic       half_pulse,
  input logic       frame_irq,
  input logic       tick,
  input logic       five_now,
  input logic       inh_now
);
  logic mode_wr, stat_rd, stat_wr;
  assign mode_wr = acc_valid & acc_write & acc_sel_mode;
  assign stat_rd = acc_valid & ~acc_write & ~acc_sel_mode;
  assign stat_wr = acc_valid & acc_write & ~acc_sel_mode;

  // R1: a pulse follows only an edge on which the parity allowed a tick
  a_r1_tick_gated: assert property (@(posedge clk) disable iff (!rst_n)
    qtr_pulse |-> $past(tick));
  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> !frame_irq);
  a_r6_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_irq && stat_wr) |=> frame_irq);
  a_r7_inhibit_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && acc_data[1]) |=> !frame_irq);
  a_r7_inhibit_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_irq) |-> !$past(inh_now));
  a_r8_no_irq_five: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_irq) |-> !$past(five_now));
  a_r9_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (!qtr_pulse && !half_pulse));
  a_r10_half_in_qtr: assert property (@(posedge clk) disable iff (!rst_n)
    half_pulse |-> qtr_pulse);
  a_r10_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    qtr_pulse |=> !qtr_pulse);
endmodule

bind frame_sequencer fs_checks u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .acc_valid    (acc_valid),
  .acc_write    (acc_write),
  .acc_sel_mode (acc_sel_mode),
  .acc_data     (acc_data),
  .qtr_pulse    (qtr_pulse),
  .half_pulse   (half_pulse),
  .frame_irq    (frame_irq),
  .tick         (tick),
  .five_now     (mode_q.five_step),
  .inh_now      (mode_q.irq_inhibit)
);

// File: tb/test_frame_sequencer.sv
module test_frame_sequencer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0, acc_write = 1'b0, acc_sel_mode = 1'b0;
  logic [1:0] acc_data = 2'b00;
  logic qtr_pulse, half_pulse, frame_irq;

  always #4 clk = ~clk;

  frame_sequencer i_frame_sequencer (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_sel_mode(acc_sel_mode), .acc_data(acc_data),
    .qtr_pulse(qtr_pulse), .half_pulse(half_pulse), .frame_irq(frame_irq));

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // reference model, built from the requirements
  bit m_par, m_five, m_inh, m_irq, m_q, m_h;
  int m_cnt;
  int k, q_first, h1, h2, irq_first;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    bit tk, mw, rd;
    int n, last;
    tk = m_par; m_par = !m_par;
    mw = acc_valid && acc_write && acc_sel_mode;
    rd = acc_valid && !acc_write && !acc_sel_mode;
    m_q = 0; m_h = 0;
    if (mw) begin
      m_cnt = 0; m_five = acc_data[0]; m_inh = acc_data[1];
      if (m_inh) m_irq = 0;
      k = 0; q_first = -1; h1 = -1; h2 = -1; irq_first = -1;
    end else begin
      k++;
      if (tk) begin
        n = m_cnt + 1;
        last = m_five ? 18641 : 14915;
        m_q = (n == 3729) || (n == 7457) || (n == 11186) || (n == last);
        m_h = (n == 7457) || (n == last);
        if (!m_five && !m_inh && n == 14915 && !rd) m_irq = 1;
        m_cnt = (n == last) ? 0 : n;
      end
      if (rd) m_irq = 0;
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    if (qtr_pulse && q_first < 0) q_first = k;
    if (half_pulse) begin
      if (h1 < 0) h1 = k; else if (h2 < 0) h2 = k;
    end
    if (frame_irq && irq_first < 0) irq_first = k;
    chk(qtr_pulse === m_q, "R1 R10 qtr_pulse vs model", int'(qtr_pulse), int'(m_q));
    chk(half_pulse === m_h, "R3 R10 half_pulse vs model", int'(half_pulse), int'(m_h));
    chk(frame_irq === m_irq, "R4 frame_irq vs model", int'(frame_irq), int'(m_irq));
    acc_valid = 0; acc_write = 0; acc_sel_mode = 0; acc_data = 2'b00;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic access(input bit wr, input bit sel, input logic [1:0] d);
    acc_valid = 1; acc_write = wr; acc_sel_mode = sel; acc_data = d;
    cyc();
  endtask

  task automatic wait_phase(input bit p);
    while (m_par != p) cyc();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    m_par = 0; m_five = 0; m_inh = 0; m_irq = 0; m_q = 0; m_h = 0; m_cnt = 0;
    k = 0; q_first = -1; h1 = -1; h2 = -1; irq_first = -1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(qtr_pulse === 0 && half_pulse === 0 && frame_irq === 0, "R11 reset outputs",
        int'({qtr_pulse, half_pulse, frame_irq}), 0);
    rst_n = 1;

    // 4-step, IRQ enabled, parity phase 0
    wait_phase(0);
    access(1, 1, 2'b00);
    run(29832);
    chk(q_first == 7457, "R2 first quarter edge", q_first, 7457);
    chk(h1 == 14913, "R3 first half edge", h1, 14913);
    chk(h2 == 29829, "R3 second half edge", h2, 29829);
    chk(irq_first == 29829, "R4 irq rise edge", irq_first, 29829);
    chk(frame_irq === 1, "R4 irq pending at 29832", int'(frame_irq), 1);

    access(1, 0, 2'b11);
    chk(frame_irq === 1, "R6 status write keeps irq", int'(frame_irq), 1);
    access(0, 1, 2'b00);
    chk(frame_irq === 1, "R6 mode read keeps irq", int'(frame_irq), 1);
    access(0, 0, 2'b00);
    chk(frame_irq === 0, "R5 status read clears irq", int'(frame_irq), 0);

    run(29832);
    chk(frame_irq === 1, "R4 irq raised next frame", int'(frame_irq), 1);
    access(1, 1, 2'b10);
    chk(frame_irq === 0, "R7 inhibit write clears irq", int'(frame_irq), 0);
    run(30000);
    chk(irq_first == -1, "R7 no irq while inhibited", irq_first, -1);

    // restart on the other parity phase
    wait_phase(1);
    access(1, 1, 2'b00);
    chk(qtr_pulse === 0 && half_pulse === 0, "R9 quiet after restart",
        int'({qtr_pulse, half_pulse}), 0);
    run(7460);
    chk(q_first == 7458, "R9 first quarter with phase 1", q_first, 7458);

    // 5-step
    wait_phase(0);
    access(1, 1, 2'b01);
    run(37290);
    chk(h1 == 14913, "R8 five-step first half", h1, 14913);
    chk(h2 == 37281, "R8 five-step second half", h2, 37281);
    chk(irq_first == -1, "R8 no irq in five-step", irq_first, -1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule